// File: doc/BRIEF.md
# Write-in-progress status read responder

This block decides what byte a byte-wide nonvolatile memory model returns on a read while an internal program or erase is running. A single-cycle start pulse, together with an operation code and the byte being written, launches a busy interval whose length in clock cycles is set by a parameter for each kind of operation. While the interval lasts, every read returns a status byte in place of the stored data. Once it ends, reads pass the array byte through unchanged.

The status byte uses its two top bits. The polling bit (bit 7) is the complement of bit 7 of the byte being programmed, or a forced 0 during either kind of erase. The alternating bit (bit 6) changes value on each read strobe and reads 1 on the first read of every operation. The low six bits carry the array byte at the read address. A busy output lets the neighbouring command decoder drop commands while the operation runs. The block also ignores any start pulse that arrives while it is busy.

Top module: `ewr_status_top`

## Requirements
- R1: After reset, busy_o is low and rdata_o equals array_i.
- R2: A start pulse while idle raises busy_o at the next clock edge. For op_i = 2'b00 (program), busy_o then stays high for exactly PROG_CYCLES cycles.
- R3: busy_o stays high for exactly SECT_CYCLES cycles for op_i = 2'b01 (sector erase) and for exactly CHIP_CYCLES cycles for op_i = 2'b10 (chip erase). The code 2'b11 behaves as chip erase.
- R4: During a program, rdata_o bit 7 is the inverse of bit 7 of wdata_i as captured with the start pulse.
- R5: During either erase, rdata_o bit 7 reads 0.
- R6: While busy, rdata_o bit 6 reads 1 on the first read strobe after the start. It then inverts after every cycle in which rd_i is high.
- R7: While busy, rdata_o bits 5..0 equal array_i bits 5..0.
- R8: Once busy_o falls, rdata_o equals array_i on every read. Bit 7 shows the true value and bit 6 no longer alternates.
- R9: A start pulse while busy_o is high has no effect. The interval, the operation and the captured bit 7 all stay as they were.
- R10: Every new operation restarts the alternating bit, so its first read returns 1 whatever state the previous operation left behind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle pulse that launches an internal write |
| op_i | input | 2 | Operation: 00 program, 01 sector erase, 10 or 11 chip erase |
| wdata_i | input | DW | Byte being programmed, captured with start_i |
| rd_i | input | 1 | Read strobe, one per read cycle |
| array_i | input | DW | Array byte at the current read address |
| rdata_o | output | DW | Byte returned to the reader |
| busy_o | output | 1 | High while the internal write runs |

## Verification
A miscounted busy timer shows up as busy_o falling one or more cycles away from the parameter value. It is caught when the interval ends, by timing the high phase against the clock period. A wrong captured operation or data bit appears as a wrong bit 7 on the very first status read. A toggle flop that is not cleared, or that flips on idle cycles, gives a wrong bit 6 on the first or second read of an operation. A launch that is accepted while busy corrupts bit 7 on the next read and stretches the interval.

// File: rtl/ewr_pkg.sv
package ewr_pkg;
  typedef enum logic [1:0] {
    WOP_PROGRAM = 2'b00,
    WOP_SECTOR  = 2'b01,
    WOP_CHIP    = 2'b10,
    WOP_CHIP_B  = 2'b11
  } wop_e;
endpackage

// File: rtl/ewr_busy_timer.sv
module ewr_busy_timer
  import ewr_pkg::*;
#(
  parameter int PROG_CYCLES = 40,
  parameter int SECT_CYCLES = 120,
  parameter int CHIP_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  wop_e op_i,
  output logic busy_o
);
  localparam int MAXC1 = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES;
  localparam int MAXC  = (MAXC1 > CHIP_CYCLES) ? MAXC1 : CHIP_CYCLES;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PROG_LD = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] SECT_LD = CW'(SECT_CYCLES - 1);
  localparam logic [CW-1:0] CHIP_LD = CW'(CHIP_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d, load_val;
  logic          busy_q, busy_d;

  always_comb begin
    unique case (op_i)
      WOP_PROGRAM: load_val = PROG_LD;
      WOP_SECTOR:  load_val = SECT_LD;
      default:     load_val = CHIP_LD;
    endcase
  end

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (launch_i) begin
      busy_d = 1'b1;
      cnt_d  = load_val;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;

  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0 && !launch_i) |=> busy_q);
  assert_busy_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == '0 && !launch_i) |=> !busy_q);
  assert_no_launch_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !launch_i);
endmodule

// File: rtl/ewr_status_regs.sv
module ewr_status_regs
  import ewr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  wop_e op_i,
  input  logic wbit7_i,
  input  logic busy_i,
  input  logic rd_i,
  output logic is_prog_o,
  output logic poll_o,
  output logic tog_o
);
  wop_e op_q, op_d;
  logic d7_q, d7_d;
  logic tog_q, tog_d;

  always_comb begin
    op_d  = op_q;
    d7_d  = d7_q;
    tog_d = tog_q;
    if (launch_i) begin
      op_d  = op_i;
      d7_d  = wbit7_i;
      tog_d = 1'b0;
    end else if (busy_i && rd_i) begin
      tog_d = ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= WOP_PROGRAM;
      d7_q  <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      op_q  <= op_d;
      d7_q  <= d7_d;
      tog_q <= tog_d;
    end
  end

  assign is_prog_o = (op_q == WOP_PROGRAM);
  assign poll_o    = is_prog_o ? ~d7_q : 1'b0;
  assign tog_o     = ~tog_q;

  assert_tog_fresh_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_i) |-> (tog_q == 1'b0));
  assert_tog_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && rd_i) |=> (tog_q != $past(tog_q)));
  assert_hold_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !launch_i) |=> ($stable(op_q) && $stable(d7_q)));
endmodule

// File: rtl/ewr_read_mux.sv
module ewr_read_mux #(
  parameter int DW = 8
) (
  input  logic          busy_i,
  input  logic          poll_i,
  input  logic          tog_i,
  input  logic [DW-1:0] array_i,
  output logic [DW-1:0] rdata_o
);
  localparam int POLL_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;

  always_comb begin
    rdata_o = array_i;
    if (busy_i) begin
      rdata_o[POLL_BIT] = poll_i;
      rdata_o[TOG_BIT]  = tog_i;
    end
  end
endmodule

// File: rtl/ewr_status_top.sv
module ewr_status_top
  import ewr_pkg::*;
#(
  parameter int DW          = 8,
  parameter int PROG_CYCLES = 40,
  parameter int SECT_CYCLES = 120,
  parameter int CHIP_CYCLES = 250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic [DW-1:0] array_i,
  output logic [DW-1:0] rdata_o,
  output logic          busy_o
);
  logic rst_s1_q, rst_s2_q;
  logic launch, poll, tog, is_prog;
  wop_e op_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  assign op_e   = wop_e'(op_i);
  assign launch = start_i && !busy_o;

  ewr_busy_timer #(
    .PROG_CYCLES(PROG_CYCLES),
    .SECT_CYCLES(SECT_CYCLES),
    .CHIP_CYCLES(CHIP_CYCLES)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .launch_i (launch),
    .op_i     (op_e),
    .busy_o   (busy_o)
  );

  ewr_status_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .launch_i  (launch),
    .op_i      (op_e),
    .wbit7_i   (wdata_i[DW-1]),
    .busy_i    (busy_o),
    .rd_i      (rd_i),
    .is_prog_o (is_prog),
    .poll_o    (poll),
    .tog_o     (tog)
  );

  ewr_read_mux #(.DW(DW)) u_mux (
    .busy_i  (busy_o),
    .poll_i  (poll),
    .tog_i   (tog),
    .array_i (array_i),
    .rdata_o (rdata_o)
  );

  assert_erase_poll_low_R5: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (busy_o && !is_prog) |-> !rdata_o[DW-1]);
  assert_idle_passthru_R8: assert property (@(posedge clk) disable iff (!rst_s2_q)
    !busy_o |-> (rdata_o == array_i));
  assert_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_s2_q)
    busy_o |-> (rdata_o[DW-3:0] == array_i[DW-3:0]));
  assert_start_rises_R2: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: tb/tb_ewr_status_top.sv
`timescale 1ns/1ps
module tb_ewr_status_top;
  localparam int PROG = 40;
  localparam int SECT = 120;
  localparam int CHIP = 250;
  localparam int PER  = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [1:0] op_i;
  logic [7:0] wdata_i;
  logic       rd_i;
  logic [7:0] array_i;
  logic [7:0] rdata_o;
  logic       busy_o;

  int vectors = 0;
  int miscompares = 0;
  time t0;

  always #2.5 clk = ~clk;

  ewr_status_top #(.DW(8), .PROG_CYCLES(PROG), .SECT_CYCLES(SECT), .CHIP_CYCLES(CHIP)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .wdata_i(wdata_i),
    .rd_i(rd_i), .array_i(array_i), .rdata_o(rdata_o), .busy_o(busy_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // at a negedge: launch, return at the negedge where busy should show
  task automatic launch_op(input logic [1:0] op, input logic [7:0] wd, input string tag);
    start_i = 1'b1; op_i = op; wdata_i = wd;
    @(negedge clk);
    start_i = 1'b0; wdata_i = 8'h00;
    t0 = $time;
    chk(tag, int'(busy_o), 1);
  endtask

  task automatic do_read(input logic [7:0] arr, input logic [7:0] exp, input string tag);
    rd_i = 1'b1; array_i = arr;
    #1 chk(tag, int'(rdata_o), int'(exp));
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic wait_idle_check(input int dur, input string tag);
    while (busy_o) @(negedge clk);
    chk(tag, int'(($time - t0) / PER), dur);
  endtask

  task automatic t_reset;
    chk("R1 busy after reset", int'(busy_o), 0);
    array_i = 8'h5A;
    #1 chk("R1 passthrough after reset", int'(rdata_o), 8'h5A);
    @(negedge clk);
  endtask

  task automatic t_program;
    launch_op(2'b00, 8'h3C, "R2 busy rises on program");
    do_read(8'hA5, 8'hE5, "R4 R6 R7 first program read");
    do_read(8'h00, 8'h80, "R6 second read toggles");
    do_read(8'hFF, 8'hFF, "R6 third read");
    do_read(8'h12, 8'h92, "R7 fourth read low bits");
    wait_idle_check(PROG, "R2 program duration");
    do_read(8'h3C, 8'h3C, "R8 true data after program");
    do_read(8'hC0, 8'hC0, "R8 toggle stopped read 1");
    do_read(8'hC0, 8'hC0, "R8 toggle stopped read 2");
  endtask

  task automatic t_sector;
    launch_op(2'b01, 8'hFF, "R3 busy rises on sector");
    do_read(8'hFF, 8'h7F, "R5 sector poll low first read");
    do_read(8'hFF, 8'h3F, "R5 R6 sector second read");
    wait_idle_check(SECT, "R3 sector duration");
    do_read(8'hFF, 8'hFF, "R8 erased data after sector");
  endtask

  task automatic t_chip;
    launch_op(2'b10, 8'h80, "R3 busy rises on chip");
    do_read(8'hFF, 8'h7F, "R5 chip poll low");
    wait_idle_check(CHIP, "R3 chip duration");
    launch_op(2'b11, 8'h00, "R3 busy rises on code 11");
    do_read(8'h81, 8'h41, "R3 code 11 reads as erase");
    wait_idle_check(CHIP, "R3 code 11 chip duration");
  endtask

  task automatic t_ignore;
    launch_op(2'b00, 8'h00, "R9 busy rises");
    repeat (3) @(negedge clk);
    start_i = 1'b1; op_i = 2'b10; wdata_i = 8'h80;
    @(negedge clk);
    start_i = 1'b0;
    do_read(8'h05, 8'hC5, "R9 op and bit7 kept");
    wait_idle_check(PROG, "R9 interval not restarted");
  endtask

  task automatic t_toggle_restart;
    launch_op(2'b00, 8'h80, "R10 busy rises");
    do_read(8'h2A, 8'h6A, "R10 first read op A");
    wait_idle_check(PROG, "R10 op A duration");
    launch_op(2'b00, 8'h80, "R10 busy rises again");
    do_read(8'h2A, 8'h6A, "R10 first read op B");
    do_read(8'h2A, 8'h2A, "R10 second read op B");
    wait_idle_check(PROG, "R10 op B duration");
  endtask

  initial begin
    #(PER * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; op_i = 2'b00; wdata_i = 8'h00;
    rd_i = 1'b0; array_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_program();
    t_sector();
    t_chip();
    t_ignore();
    t_toggle_restart();
    repeat (2) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule